// File: doc/BRIEF.md
# eMMC Boot Read Sequencer

This block is a hardware boot master that brings up an eMMC card and copies a run of blocks into local word storage, with no processor involved. It drives the 32-bit register interface of a separate eMMC host controller through a request/acknowledge master port. It plays out a fixed script over that port. The script first resets and configures the controller. It then walks the card through identification and selection and sets the block length. Last, for each block, it checks the card status and issues a single-block read, then unloads the data words one at a time.

A pulse on `start` latches a starting block number and a block count. Each data word leaves on a valid/ready stream together with its local word address. While `mem_valid` is high and `mem_ready` is low, the word and the address are held unchanged, and the sequencer issues no further bus access until the word is accepted. When the run finishes, the block raises `done`. When a poll runs out, the card never reports ready, or a status check fails, the block raises `err` and stops at once.

Every command follows the same pattern. The sequencer clears the controller's interrupt register, writes the argument, and writes the command word. It then polls the interrupt register for a completion bit and writes the polled value back with only that bit cleared.

Top module: `emmc_boot_seq`

## Requirements
- R1: After reset, and whenever no run is in progress, `busy`, `bus_req` and `mem_valid` are low. After reset, `done` and `err` are also low.
- R2: A run begins with five writes in this order: 0x80000000 to offset 0x7C, then 0x0 to 0x7C, then 0x00010000 to 0x1C, then BLK_BYTES to 0x14, then the clock word for divider code SLOW_CODE to 0x18. A clock word is 0x01002FFF OR (code << 16).
- R3: Every command is sent as three writes: 0x0 to 0x40, then the argument to 0x08, then the command word to 0x00.
- R4: After each command, 0x40 is read repeatedly until the awaited mask bit is set. The completion mask is 0x00010000. The value read is then written back to 0x40 with that mask bit cleared and all other bits kept.
- R5: If POLL_LIMIT reads of 0x40 in a row miss the mask bit, the run ends with `err` high and no further bus access is made.
- R6: The identification and setup commands are issued in this order: word 0x00000040 with argument 0; word 0x01405040 with argument 0x40300000; word 0x02806040 with argument 0; word 0x03400040 with argument 0x00010000; then the clock word for FAST_CODE is written to 0x18; then word 0x09806000 and word 0x07400000, each with argument 0x00010000; then word 0x10400000 with argument BLK_BYTES.
- R7: After each 0x01405040 command, offset 0x2C is read. If bit 31 is clear, the command is issued again. If RETRY_LIMIT such commands have all failed, the run ends with `err`.
- R8: For block k, word 0x0D400000 with argument 0x00010000 is issued, and 0x2C must then read exactly 0x00000900. Any other value ends the run with `err`, and no read command is issued for that block.
- R9: The read command is word 0x11480000 with argument (first_blk + k) * BLK_BYTES, kept to 32 bits. After its completion poll, 0x40 is polled again for mask 0x00100000 and written back with that bit cleared. Then BLK_BYTES/4 reads are made from 0x34.
- R10: The i-th word read for block k leaves on the stream with `mem_addr` = k*(BLK_BYTES/4) + i. The word and address hold stable while `mem_valid` is high and `mem_ready` is low.
- R11: With `blk_cnt` = 0, the run ends with `done` after the 0x10400000 command, and no block command is issued.
- R12: `done` and `err` are never high together. Each stays high until the next accepted `start`. A `start` pulse while `busy` is high has no effect.
- R13: `bus_req` stays high, with address, direction and write data held, until the cycle in which `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| first_blk | input | 32 | First card block number |
| blk_cnt | input | CNT_W | Number of blocks to copy |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| err | output | 1 | Last run aborted |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completed this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| mem_valid | output | 1 | Data word available |
| mem_ready | input | 1 | Sink accepts the word |
| mem_addr | output | CNT_W+log2(BLK_BYTES/4) | Local word address |
| mem_data | output | 32 | Data word |

## Verification
The bench builds the block with BLK_BYTES=16 (four words per block), CNT_W=4, POLL_LIMIT=5 and RETRY_LIMIT=3. With these values, poll exhaustion, a poll that hits on its last allowed read, and retry exhaustion of the ready loop all happen within a few hundred cycles. A behavioural controller model answers the bus with a configurable completion delay and with scripted ready and status responses. The bench sweeps block counts 0 to 3 over several start blocks and delays, and injects a status failure at chosen blocks. Every command, every write-back and every streamed word is compared against lists computed arithmetically in the bench.

// File: rtl/emmc_boot_pkg.sv
package emmc_boot_pkg;

  typedef enum logic [3:0] {
    K_WR, K_CMD, K_RDY, K_STAT, K_LOOP, K_POLLD, K_UNLOAD, K_NEXT
  } step_kind_t;

  typedef struct packed {
    step_kind_t  kind;
    logic        blk_arg;
    logic [7:0]  addr;
    logic [31:0] word;
    logic [31:0] arg;
  } step_t;

  typedef enum logic [3:0] {
    S_IDLE, S_DEC, S_WR, S_CCLR, S_CARG, S_CCMD,
    S_PRD, S_PWB, S_RSP, S_URD, S_UPUSH
  } fsm_t;

  localparam logic [7:0] REG_CMD   = 8'h00;
  localparam logic [7:0] REG_ARG   = 8'h08;
  localparam logic [7:0] REG_BLKSZ = 8'h14;
  localparam logic [7:0] REG_CLK   = 8'h18;
  localparam logic [7:0] REG_ACC   = 8'h1C;
  localparam logic [7:0] REG_RSP   = 8'h2C;
  localparam logic [7:0] REG_DATA  = 8'h34;
  localparam logic [7:0] REG_INT   = 8'h40;
  localparam logic [7:0] REG_RST   = 8'h7C;

  localparam logic [31:0] MASK_CC   = 32'h0001_0000;
  localparam logic [31:0] MASK_DATA = 32'h0010_0000;
  localparam logic [31:0] STAT_OK   = 32'h0000_0900;

  localparam logic [4:0] STEP_CMD1 = 5'd6;
  localparam logic [4:0] STEP_LOOP = 5'd14;

  function automatic logic [31:0] clk_word(input logic [3:0] code);
    return 32'h0100_2FFF | ({28'd0, code} << 16);
  endfunction

endpackage

// File: rtl/emmc_boot_script.sv
module emmc_boot_script
  import emmc_boot_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int SLOW_CODE = 7,
  parameter int FAST_CODE = 1
) (
  input  logic [4:0] idx,
  output step_t      st
);
  localparam logic [31:0] BB = 32'(BLK_BYTES);
  localparam logic [31:0] CK_SLOW = clk_word(4'(SLOW_CODE));
  localparam logic [31:0] CK_FAST = clk_word(4'(FAST_CODE));

  always_comb begin
    st = '{kind: K_LOOP, blk_arg: 1'b0, addr: 8'h00, word: 32'h0, arg: 32'h0};
    unique case (idx)
      5'd0:  st = '{K_WR,  1'b0, REG_RST,   32'h8000_0000, 32'h0};
      5'd1:  st = '{K_WR,  1'b0, REG_RST,   32'h0,         32'h0};
      5'd2:  st = '{K_WR,  1'b0, REG_ACC,   32'h0001_0000, 32'h0};
      5'd3:  st = '{K_WR,  1'b0, REG_BLKSZ, BB,            32'h0};
      5'd4:  st = '{K_WR,  1'b0, REG_CLK,   CK_SLOW,       32'h0};
      5'd5:  st = '{K_CMD, 1'b0, REG_CMD,   32'h0000_0040, 32'h0};
      5'd6:  st = '{K_CMD, 1'b0, REG_CMD,   32'h0140_5040, 32'h4030_0000};
      5'd7:  st = '{K_RDY, 1'b0, REG_RSP,   32'h0,         32'h0};
      5'd8:  st = '{K_CMD, 1'b0, REG_CMD,   32'h0280_6040, 32'h0};
      5'd9:  st = '{K_CMD, 1'b0, REG_CMD,   32'h0340_0040, 32'h0001_0000};
      5'd10: st = '{K_WR,  1'b0, REG_CLK,   CK_FAST,       32'h0};
      5'd11: st = '{K_CMD, 1'b0, REG_CMD,   32'h0980_6000, 32'h0001_0000};
      5'd12: st = '{K_CMD, 1'b0, REG_CMD,   32'h0740_0000, 32'h0001_0000};
      5'd13: st = '{K_CMD, 1'b0, REG_CMD,   32'h1040_0000, BB};
      5'd14: st = '{K_LOOP, 1'b0, REG_CMD,  32'h0,         32'h0};
      5'd15: st = '{K_CMD, 1'b0, REG_CMD,   32'h0D40_0000, 32'h0001_0000};
      5'd16: st = '{K_STAT, 1'b0, REG_RSP,  32'h0,         32'h0};
      5'd17: st = '{K_CMD, 1'b1, REG_CMD,   32'h1148_0000, 32'h0};
      5'd18: st = '{K_POLLD, 1'b0, REG_INT, 32'h0,         32'h0};
      5'd19: st = '{K_UNLOAD, 1'b0, REG_DATA, 32'h0,       32'h0};
      5'd20: st = '{K_NEXT, 1'b0, REG_CMD,  32'h0,         32'h0};
      default: ;
    endcase
  end
endmodule

// File: rtl/emmc_boot_ctr.sv
module emmc_boot_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/emmc_boot_bus.sv
module emmc_boot_bus (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic        fin,
  output logic [31:0] rdata,
  output logic        bus_req,
  output logic        bus_we,
  output logic [7:0]  bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata
);
  typedef enum logic [1:0] {E_IDLE, E_ACT, E_FIN} eng_t;
  eng_t es_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      es_q      <= E_IDLE;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rdata     <= '0;
    end else begin
      unique case (es_q)
        E_IDLE: if (go) begin
          bus_req   <= 1'b1;
          bus_we    <= we_i;
          bus_addr  <= addr_i;
          bus_wdata <= wdata_i;
          es_q      <= E_ACT;
        end
        E_ACT: if (bus_ack) begin
          bus_req <= 1'b0;
          rdata   <= bus_rdata;
          es_q    <= E_FIN;
        end
        default: es_q <= E_IDLE;
      endcase
    end
  end

  assign fin = (es_q == E_FIN);

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
endmodule

// File: rtl/emmc_boot_seq.sv
module emmc_boot_seq
  import emmc_boot_pkg::*;
#(
  parameter int BLK_BYTES   = 512,
  parameter int CNT_W       = 16,
  parameter int POLL_LIMIT  = 1000000,
  parameter int RETRY_LIMIT = 65535,
  parameter int SLOW_CODE   = 7,
  parameter int FAST_CODE   = 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [31:0]                            first_blk,
  input  logic [CNT_W-1:0]                       blk_cnt,
  output logic                                   busy,
  output logic                                   done,
  output logic                                   err,
  output logic                                   bus_req,
  output logic                                   bus_we,
  output logic [7:0]                             bus_addr,
  output logic [31:0]                            bus_wdata,
  input  logic                                   bus_ack,
  input  logic [31:0]                            bus_rdata,
  output logic                                   mem_valid,
  input  logic                                   mem_ready,
  output logic [CNT_W+$clog2(BLK_BYTES/4)-1:0]   mem_addr,
  output logic [31:0]                            mem_data
);
  localparam int WORDS   = BLK_BYTES / 4;
  localparam int WORD_AW = $clog2(WORDS);
  localparam int PCNT_W  = $clog2(POLL_LIMIT + 1);
  localparam int RCNT_W  = $clog2(RETRY_LIMIT + 1);

  fsm_t        state_q;
  logic [4:0]  step_q;
  step_t       st;
  logic [31:0] mask_q, wb_q, first_q;
  logic [CNT_W-1:0] cnt_q;

  logic        eng_go, eng_we, eng_fin;
  logic [7:0]  eng_addr;
  logic [31:0] eng_wd, eng_rd;

  logic [PCNT_W-1:0]  pc_q;
  logic [RCNT_W-1:0]  rt_q;
  logic [WORD_AW-1:0] wd_q;
  logic [CNT_W-1:0]   bk_q;
  logic pc_clr, pc_inc, rt_clr, rt_inc, wd_clr, wd_inc, bk_clr, bk_inc;
  logic pc_last, rt_last, wd_last, hit;
  logic [31:0] cmd17_arg;

  emmc_boot_script #(
    .BLK_BYTES(BLK_BYTES), .SLOW_CODE(SLOW_CODE), .FAST_CODE(FAST_CODE)
  ) u_script (.idx(step_q), .st(st));

  emmc_boot_bus u_bus (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .we_i(eng_we), .addr_i(eng_addr),
    .wdata_i(eng_wd), .fin(eng_fin), .rdata(eng_rd),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  emmc_boot_ctr #(.W(PCNT_W))  u_poll  (.clk(clk), .rst_n(rst_n), .clr(pc_clr), .inc(pc_inc), .q(pc_q));
  emmc_boot_ctr #(.W(RCNT_W))  u_retry (.clk(clk), .rst_n(rst_n), .clr(rt_clr), .inc(rt_inc), .q(rt_q));
  emmc_boot_ctr #(.W(WORD_AW)) u_word  (.clk(clk), .rst_n(rst_n), .clr(wd_clr), .inc(wd_inc), .q(wd_q));
  emmc_boot_ctr #(.W(CNT_W))   u_blk   (.clk(clk), .rst_n(rst_n), .clr(bk_clr), .inc(bk_inc), .q(bk_q));

  assign cmd17_arg = (first_q + 32'(bk_q)) * 32'(BLK_BYTES);
  assign pc_last   = (pc_q == PCNT_W'(POLL_LIMIT - 1));
  assign rt_last   = (rt_q == RCNT_W'(RETRY_LIMIT - 1));
  assign wd_last   = (wd_q == WORD_AW'(WORDS - 1));
  assign hit       = |(eng_rd & mask_q);
  assign busy      = (state_q != S_IDLE);
  assign mem_addr  = {bk_q, wd_q};

  // Access presented to the bus engine in each state.
  always_comb begin
    eng_go   = 1'b1;
    eng_we   = 1'b1;
    eng_addr = REG_INT;
    eng_wd   = 32'h0;
    unique case (state_q)
      S_WR:   begin eng_addr = st.addr; eng_wd = st.word; end
      S_CCLR: ;
      S_CARG: begin eng_addr = REG_ARG; eng_wd = st.blk_arg ? cmd17_arg : st.arg; end
      S_CCMD: begin eng_addr = REG_CMD; eng_wd = st.word; end
      S_PRD:  eng_we = 1'b0;
      S_PWB:  eng_wd = wb_q & ~mask_q;
      S_RSP:  begin eng_we = 1'b0; eng_addr = REG_RSP; end
      S_URD:  begin eng_we = 1'b0; eng_addr = REG_DATA; end
      default: eng_go = 1'b0;
    endcase
  end

  // Counter control.
  always_comb begin
    pc_clr = (state_q == S_CCMD && eng_fin) || (state_q == S_DEC && st.kind == K_POLLD);
    pc_inc = (state_q == S_PRD) && eng_fin && !hit && !pc_last;
    rt_clr = (state_q == S_IDLE) && start;
    rt_inc = (state_q == S_RSP) && eng_fin && st.kind == K_RDY && !eng_rd[31] && !rt_last;
    wd_clr = (state_q == S_DEC) && st.kind == K_UNLOAD;
    wd_inc = (state_q == S_UPUSH) && mem_ready && !wd_last;
    bk_clr = (state_q == S_IDLE) && start;
    bk_inc = (state_q == S_DEC) && st.kind == K_NEXT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      step_q    <= '0;
      mask_q    <= MASK_CC;
      wb_q      <= '0;
      first_q   <= '0;
      cnt_q     <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      mem_valid <= 1'b0;
      mem_data  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          first_q <= first_blk;
          cnt_q   <= blk_cnt;
          step_q  <= '0;
          done    <= 1'b0;
          err     <= 1'b0;
          state_q <= S_DEC;
        end
        S_DEC: begin
          unique case (st.kind)
            K_WR:  state_q <= S_WR;
            K_CMD: begin mask_q <= MASK_CC; state_q <= S_CCLR; end
            K_RDY, K_STAT: state_q <= S_RSP;
            K_LOOP: begin
              if (bk_q == cnt_q) begin done <= 1'b1; state_q <= S_IDLE; end
              else step_q <= step_q + 5'd1;
            end
            K_POLLD:  begin mask_q <= MASK_DATA; state_q <= S_PRD; end
            K_UNLOAD: state_q <= S_URD;
            default:  step_q <= STEP_LOOP;
          endcase
        end
        S_WR: if (eng_fin) begin step_q <= step_q + 5'd1; state_q <= S_DEC; end
        S_CCLR: if (eng_fin) state_q <= S_CARG;
        S_CARG: if (eng_fin) state_q <= S_CCMD;
        S_CCMD: if (eng_fin) state_q <= S_PRD;
        S_PRD: if (eng_fin) begin
          if (hit) begin wb_q <= eng_rd; state_q <= S_PWB; end
          else if (pc_last) begin err <= 1'b1; state_q <= S_IDLE; end
        end
        S_PWB: if (eng_fin) begin step_q <= step_q + 5'd1; state_q <= S_DEC; end
        S_RSP: if (eng_fin) begin
          if (st.kind == K_RDY) begin
            if (eng_rd[31]) begin step_q <= step_q + 5'd1; state_q <= S_DEC; end
            else if (rt_last) begin err <= 1'b1; state_q <= S_IDLE; end
            else begin step_q <= STEP_CMD1; state_q <= S_DEC; end
          end else begin
            if (eng_rd == STAT_OK) begin step_q <= step_q + 5'd1; state_q <= S_DEC; end
            else begin err <= 1'b1; state_q <= S_IDLE; end
          end
        end
        S_URD: if (eng_fin) begin
          mem_valid <= 1'b1;
          mem_data  <= eng_rd;
          state_q   <= S_UPUSH;
        end
        S_UPUSH: if (mem_ready) begin
          mem_valid <= 1'b0;
          if (wd_last) begin step_q <= step_q + 5'd1; state_q <= S_DEC; end
          else state_q <= S_URD;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r12_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data) && $stable(mem_addr)));
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !mem_valid));
  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q < PCNT_W'(POLL_LIMIT));
  a_r7_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rt_q < RCNT_W'(RETRY_LIMIT));
  a_r10_no_push_while_bus: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !bus_req);
endmodule

// File: tb/emmc_boot_seq_tb_top.sv
module emmc_boot_seq_tb_top;
  localparam int BB = 16, CW = 4, PL = 5, RL = 3, W = BB / 4;
  localparam logic [31:0] C1 = 32'h0140_5040, C13 = 32'h0D40_0000, C17 = 32'h1148_0000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] first_blk = 0;
  logic [CW-1:0] blk_cnt = 0;
  logic busy, done, err, bus_req, bus_we, mem_valid;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, mem_data;
  logic bus_ack = 0, mem_ready = 0;
  logic [31:0] bus_rdata = 0;
  logic [CW+1:0] mem_addr;

  emmc_boot_seq #(.BLK_BYTES(BB), .CNT_W(CW), .POLL_LIMIT(PL), .RETRY_LIMIT(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .first_blk(first_blk), .blk_cnt(blk_cnt),
    .busy(busy), .done(done), .err(err), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Controller model state.
  int D, n1_need, bad13, n1_seen, n13, n_cmd, n_wr, n_acc, n_rd40, rd_since, fast_at, wcnt;
  int trip_bad, wb_bad, hold_bad, n_cap, rdy_mode, ph;
  logic [31:0] int_reg, last_int, arg_reg, cur_cmd, cur_blk;
  bit fired, cc_pend, prev_v, prev_acc;
  logic [7:0] p1a, p2a; logic [31:0] p1d, p2d, pd; logic [CW+1:0] pa;
  logic [31:0] log_c[64], log_a[64], exp_c[64], exp_a[64], wr_a[8], wr_d[8], cap[64];
  int exp_n;

  function automatic logic [31:0] pat(input logic [31:0] b, input int w);
    return {8'hA5, b[11:0], 12'(w)};
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (bus_ack) bus_ack = 0;
    else if (bus_req) begin
      bus_ack = 1; n_acc++;
      if (bus_we) begin
        if (n_wr < 8) begin wr_a[n_wr] = bus_addr; wr_d[n_wr] = bus_wdata; end
        n_wr++;
        case (bus_addr)
          8'h40: begin
            if (bus_wdata != 0) begin
              if (bus_wdata !== (last_int & ~(cc_pend ? 32'h0001_0000 : 32'h0010_0000))) wb_bad++;
              if (cc_pend && rd_since != D + 1) wb_bad++;
              cc_pend = 0;
            end
            int_reg = bus_wdata;
          end
          8'h08: arg_reg = bus_wdata;
          8'h18: if (bus_wdata == 32'h0101_2FFF) fast_at = n_cmd;
          8'h00: begin
            if (!(p1a == 8'h08 && p1d == arg_reg && p2a == 8'h40 && p2d == 0)) trip_bad++;
            if (n_cmd < 64) begin log_c[n_cmd] = bus_wdata; log_a[n_cmd] = arg_reg; end
            n_cmd++; cur_cmd = bus_wdata; fired = 0; cc_pend = 1; rd_since = 0;
            if (bus_wdata == C17) begin cur_blk = arg_reg / BB; wcnt = 0; end
          end
          default: ;
        endcase
        p2a = p1a; p2d = p1d; p1a = bus_addr; p1d = bus_wdata;
      end else begin
        case (bus_addr)
          8'h40: begin
            rd_since++; n_rd40++;
            if (!fired) begin
              if (D == 0 || rd_since > D) begin
                int_reg |= 32'h1 | 32'h0001_0000 | ((cur_cmd == C17) ? 32'h0010_0000 : 32'h0);
                fired = 1;
              end
            end
            last_int = int_reg; bus_rdata = int_reg;
          end
          8'h2C: begin
            if (cur_cmd == C1) begin
              n1_seen++;
              bus_rdata = (n1_need != 0 && n1_seen >= n1_need) ? 32'h80FF_8000 : 32'h00FF_8000;
            end else if (cur_cmd == C13) begin
              bus_rdata = (n13 == bad13) ? 32'h0000_0B00 : 32'h0000_0900; n13++;
            end else bus_rdata = 32'h0;
          end
          8'h34: begin bus_rdata = pat(cur_blk, wcnt); wcnt++; end
          default: bus_rdata = 32'hDEAD_BEEF;
        endcase
      end
    end
    // Stream sink with back-pressure.
    ph++;
    mem_ready = (rdy_mode == 0) ? 1'b1 : ((ph % 3) != 2);
    if (prev_v && !prev_acc && (!mem_valid || mem_addr != pa || mem_data != pd)) hold_bad++;
    if (mem_valid && mem_ready) begin cap[mem_addr] = mem_data; n_cap++; end
    prev_v = mem_valid; prev_acc = mem_valid && mem_ready; pa = mem_addr; pd = mem_data;
    if (cyc > 190000) begin
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic model_reset(input int d, input int n1, input int b13, input int rm);
    D = d; n1_need = n1; bad13 = b13; rdy_mode = rm;
    n1_seen = 0; n13 = 0; n_cmd = 0; n_wr = 0; n_acc = 0; n_rd40 = 0; rd_since = 0;
    fast_at = -1; wcnt = 0; trip_bad = 0; wb_bad = 0; hold_bad = 0; n_cap = 0;
    int_reg = 0; last_int = 0; arg_reg = 0; cur_cmd = 0; cur_blk = 0; fired = 1; cc_pend = 0;
    p1a = 0; p2a = 0; p1d = 1; p2d = 1; prev_v = 0; prev_acc = 0;
    for (int i = 0; i < 64; i++) cap[i] = 32'h0;
  endtask

  task automatic push(input logic [31:0] c, input logic [31:0] a);
    exp_c[exp_n] = c; exp_a[exp_n] = a; exp_n++;
  endtask

  // Expected command list and outcome computed from the requirements.
  task automatic build(input logic [31:0] f, input int cnt, output bit ok, output int nblk);
    int n1;
    exp_n = 0; ok = 1; nblk = 0;
    push(32'h0000_0040, 0);
    if (D >= PL) begin ok = 0; return; end
    n1 = (n1_need == 0 || n1_need > RL) ? RL : n1_need;
    for (int i = 0; i < n1; i++) push(C1, 32'h4030_0000);
    if (n1_need == 0 || n1_need > RL) begin ok = 0; return; end
    push(32'h0280_6040, 0); push(32'h0340_0040, 32'h0001_0000);
    push(32'h0980_6000, 32'h0001_0000); push(32'h0740_0000, 32'h0001_0000);
    push(32'h1040_0000, BB);
    for (int k = 0; k < cnt; k++) begin
      push(C13, 32'h0001_0000);
      if (k == bad13) begin ok = 0; return; end
      push(C17, (f + k) * BB);
      nblk++;
    end
  endtask

  task automatic run(input logic [31:0] f, input int cnt, input int d, input int n1,
                     input int b13, input int rm, input bit poke);
    bit ok; int nblk, t, miss, acc0;
    string tag;
    model_reset(d, n1, b13, rm);
    build(f, cnt, ok, nblk);
    first_blk = f; blk_cnt = CW'(cnt); start = 1;
    @(negedge clk); start = 0;
    t = 0;
    while ((busy || t < 2) && t < 20000) begin
      @(negedge clk); t++;
      if (poke && t == 40) begin first_blk = f + 5; blk_cnt = 0; start = 1; end
      if (poke && t == 41) start = 0;
    end
    chk(t < 20000, "watchdog run timeout", t, 20000);
    tag = !ok ? "R5/R7/R8 abort outcome" : (cnt == 0 ? "R11 empty run outcome" : "R12 outcome");
    chk(done == ok && err == !ok, tag, {done, err}, {ok, !ok});
    miss = -1;
    for (int i = 0; i < exp_n && i < 64; i++)
      if (miss < 0 && (log_c[i] != exp_c[i] || log_a[i] != exp_a[i])) miss = i;
    chk(n_cmd == exp_n && miss < 0, "R6/R7/R8/R9 command list", n_cmd, exp_n);
    chk(wr_a[0] == 8'h7C && wr_d[0] == 32'h8000_0000 && wr_a[1] == 8'h7C && wr_d[1] == 0 &&
        wr_a[2] == 8'h1C && wr_d[2] == 32'h0001_0000 && wr_a[3] == 8'h14 && wr_d[3] == BB &&
        wr_a[4] == 8'h18 && wr_d[4] == 32'h0107_2FFF, "R2 init writes", wr_d[4], 32'h0107_2FFF);
    chk(trip_bad == 0, "R3 command write triplet", trip_bad, 0);
    chk(wb_bad == 0, "R4 poll write-back", wb_bad, 0);
    if (ok || nblk > 0 || b13 < cnt)
      chk(fast_at == 3 + n1, "R6 fast clock placement", fast_at, 3 + n1);
    chk(n_cap == nblk * W, "R9 word count", n_cap, nblk * W);
    miss = 0;
    for (int k = 0; k < nblk; k++)
      for (int w = 0; w < W; w++)
        if (cap[k * W + w] != pat(f + k, w)) miss++;
    chk(miss == 0, "R10 stream address/data", miss, 0);
    chk(hold_bad == 0, "R10 back-pressure hold", hold_bad, 0);
    acc0 = n_acc;
    repeat (6) @(negedge clk);
    chk(done == ok && err == !ok && n_acc == acc0 && !busy && !bus_req && !mem_valid,
        "R12 flags held, R1 idle quiet", n_acc, acc0);
    if (d >= PL) chk(n_rd40 == PL && n_cmd == 1, "R5 poll limit read count", n_rd40, PL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !bus_req && !mem_valid, "R1 reset state",
        {busy, done, err, bus_req, mem_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_req && !mem_valid, "R1 idle after reset", {busy, bus_req, mem_valid}, 0);
    // Sweep counts, start blocks and completion delays (D=4 hits on the last allowed read).
    for (int c = 0; c < 4; c++)
      for (int fi = 0; fi < 3; fi++)
        run((fi == 0) ? 32'd0 : (fi == 1) ? 32'd9 : 32'h1000_0001, c,
            (c + fi) % 3 * 2, 1 + (c % 3), 99, fi % 2, 0);
    run(32'd4, 3, 1, 2, 1, 1, 0);     // R8 status failure on second block
    run(32'd2, 2, 0, 1, 0, 0, 0);     // R8 status failure on first block
    run(32'd1, 1, 0, 0, 99, 0, 0);    // R7 ready never set: exhaustion
    run(32'd1, 1, 0, 3, 99, 0, 0);    // R7 ready on last permitted try
    run(32'd0, 2, PL, 1, 99, 0, 0);   // R5 poll timeout on first command
    run(32'd6, 3, 2, 2, 99, 1, 1);    // R12 start pulse while busy ignored
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule